// File: doc/BRIEF.md
# Modulo-N Issue Queue Steering Unit

This unit picks which of several issue queues receives an instruction at dispatch. The queues are used in turn, round-robin. A primary pointer names the current target queue. The pointer moves on to the next queue only after a fixed number of instructions have been placed in the current one, so instructions reach each queue in groups.

Each queue reports three reject reasons: full, capped, and out of bandwidth. Each queue also reports how many free slots it has. When the target queue rejects while it still has free slots, the unit counts a stall and adds the free-slot count to an accumulator. These counters measure how much capacity the rejects leave unused.

The unit has a relaxed mode, chosen per request, that copes with a rejecting target. In this mode the unit looks at the queues that follow the target, wrapping around, and takes the first queue that accepts. A placement found this way leaves the primary pointer and its group count unchanged. In the strict mode, a rejecting target ends the request with no placement.

Top module: `modn_steer`

## Requirements
- R1: After a synchronous reset, `res_valid`, `stall_cnt` and `free_acc` are 0, and the primary pointer is queue 0.
- R2: `res_valid` is 1 exactly one cycle after a cycle with `req` high, and 0 otherwise. When `req` is low, the other result fields keep their values.
- R3: If the primary queue accepts (none of its full, cap or bandwidth flags is set), the result gives `res_found`=1, `res_q`=primary pointer, `res_loose`=0 and `res_cause`=0.
- R4: A placement in the primary queue with `disp_ok` high counts toward a group. After GROUP such placements the pointer advances to (pointer+1) mod NQ. A request with `disp_ok` low changes nothing.
- R5: A rejecting queue's cause code is 1 if it is full, otherwise 2 if it is capped, otherwise 3 if it is out of bandwidth. When no queue is found, `res_cause` carries the primary queue's code and `res_q` is the primary pointer.
- R6: With `loose_en` low and a rejecting primary queue, the result is `res_found`=0 and `res_loose`=0. No other queue is considered.
- R7: With `loose_en` high and a rejecting primary queue, the unit checks queues pointer+1, pointer+2, and so on, modulo NQ. It selects the first queue that accepts, with `res_found`=1, `res_loose`=1 and `res_cause`=0.
- R8: With `loose_en` high, if every queue rejects, the search ends back at the primary queue and reports `res_found`=0 with the primary queue's cause.
- R9: A placement found by the relaxed search leaves both the primary pointer and the group count unchanged, even when `disp_ok` is high.
- R10: For each request whose primary queue rejects while reporting a nonzero free count, `stall_cnt` grows by 1 and `free_acc` grows by that free count. Both counters wrap at their widths. A zero free count leaves both unchanged.
- R11: The stall accounting in R10 applies in both modes. It still happens in a cycle where the relaxed search places the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | An instruction wants a queue this cycle |
| loose_en | input | 1 | Allow a search beyond a rejecting primary queue |
| disp_ok | input | 1 | The dispatch goes ahead if a queue is found |
| q_full | input | NQ | Per-queue full flag |
| q_cap | input | NQ | Per-queue cap-reached flag |
| q_bw | input | NQ | Per-queue bandwidth-spent flag |
| q_free | input | NQ*FW | Per-queue free-slot counts; queue i in bits [i*FW +: FW] |
| res_valid | output | 1 | The result fields below belong to last cycle's request |
| res_found | output | 1 | A queue was selected |
| res_q | output | IW | Selected queue, or the primary queue if none was found |
| res_loose | output | 1 | The selection came from the relaxed search |
| res_cause | output | 2 | Reject code: 0 none, 1 full, 2 cap, 3 bandwidth |
| stall_cnt | output | CW | Count of primary rejects that still had free slots |
| free_acc | output | AW | Sum of the free slots seen at those rejects |

## Verification
A single request can both register a stall on the primary queue and be placed elsewhere by the relaxed search. In that cycle the counters must move while the pointer and group count must stay still. The bench creates this case directly: it sets a reject flag and a nonzero free count on the primary queue, leaves a later queue accepting, and holds `disp_ok` high. A random phase then mixes modes, flags and free counts so that such cycles also occur together with pointer advances on later requests. A behavioural model that tracks the pointer, the group count and both counters compares every output on every cycle.

// File: rtl/modn_steer_pkg.sv
package modn_steer_pkg;
  typedef enum logic [1:0] {
    RJ_NONE = 2'd0,
    RJ_FULL = 2'd1,
    RJ_CAP  = 2'd2,
    RJ_BW   = 2'd3
  } rej_e;
endpackage

// File: rtl/modn_steer_cause.sv
module modn_steer_cause
  import modn_steer_pkg::*;
#(
  parameter int NQ = 4
) (
  input  logic [NQ-1:0]      q_full,
  input  logic [NQ-1:0]      q_cap,
  input  logic [NQ-1:0]      q_bw,
  output logic [NQ-1:0]      q_ok,
  output logic [NQ-1:0][1:0] q_rej
);
  for (genvar g = 0; g < NQ; g++) begin : g_q
    always_comb begin
      q_ok[g] = !(q_full[g] || q_cap[g] || q_bw[g]);
      if (q_full[g])     q_rej[g] = RJ_FULL;
      else if (q_cap[g]) q_rej[g] = RJ_CAP;
      else if (q_bw[g])  q_rej[g] = RJ_BW;
      else               q_rej[g] = RJ_NONE;
    end
  end
endmodule

// File: rtl/modn_steer_search.sv
module modn_steer_search #(
  parameter int NQ = 4,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic [NQ-1:0] ok,
  input  logic [IW-1:0] start,
  input  logic          loose_en,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic          via_loose
);
  function automatic logic [IW-1:0] wrap_idx(input int v);
    int r;
    r = (v >= NQ) ? v - NQ : v;
    return IW'(r);
  endfunction

  always_comb begin
    hit       = 1'b0;
    idx       = start;
    via_loose = 1'b0;
    if (ok[start]) begin
      hit = 1'b1;
    end else if (loose_en) begin
      // walk backwards so the nearest following queue wins
      for (int k = NQ - 1; k >= 1; k--) begin
        if (ok[wrap_idx(int'(start) + k)]) begin
          hit       = 1'b1;
          idx       = wrap_idx(int'(start) + k);
          via_loose = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/modn_steer_ptr.sv
module modn_steer_ptr #(
  parameter int NQ    = 4,
  parameter int GROUP = 2,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int GW = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  logic [GW-1:0] grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      grp <= '0;
    end else if (adv) begin
      if (grp == GW'(GROUP - 1)) begin
        grp <= '0;
        ptr <= (ptr == IW'(NQ - 1)) ? '0 : ptr + 1'b1;
      end else begin
        grp <= grp + 1'b1;
      end
    end
  end

  // R4: the pointer only ever steps to the next queue
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(ptr) |-> ptr == (($past(ptr) == IW'(NQ - 1)) ? '0 : $past(ptr) + 1'b1));

  // R9: without a primary placement the pointer holds
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(adv) |-> $stable(ptr));
endmodule

// File: rtl/modn_steer_stats.sv
module modn_steer_stats #(
  parameter int FW = 4,
  parameter int CW = 8,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt,
  input  logic [FW-1:0] free,
  output logic [CW-1:0] stall_cnt,
  output logic [AW-1:0] free_acc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stall_cnt <= '0;
      free_acc  <= '0;
    end else if (evt) begin
      stall_cnt <= stall_cnt + 1'b1;
      free_acc  <= free_acc + AW'(free);
    end
  end

  // R10: the accumulator moves together with the stall count
  p_acc_with_stall_r10: assert property (@(posedge clk) disable iff (rst)
    $stable(stall_cnt) |-> $stable(free_acc));
endmodule

// File: rtl/modn_steer.sv
module modn_steer
  import modn_steer_pkg::*;
#(
  parameter int NQ    = 4,
  parameter int FW    = 4,
  parameter int GROUP = 2,
  parameter int CW    = 8,
  parameter int AW    = 10,
  localparam int IW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             loose_en,
  input  logic             disp_ok,
  input  logic [NQ-1:0]    q_full,
  input  logic [NQ-1:0]    q_cap,
  input  logic [NQ-1:0]    q_bw,
  input  logic [NQ*FW-1:0] q_free,
  output logic             res_valid,
  output logic             res_found,
  output logic [IW-1:0]    res_q,
  output logic             res_loose,
  output logic [1:0]       res_cause,
  output logic [CW-1:0]    stall_cnt,
  output logic [AW-1:0]    free_acc
);
  logic [NQ-1:0]      q_ok;
  logic [NQ-1:0][1:0] q_rej;
  logic [IW-1:0]      ptr;
  logic [IW-1:0]      pick;
  logic               hit;
  logic               via_loose;
  logic [FW-1:0]      prim_free;
  logic               stall_evt;
  logic               adv;

  modn_steer_cause #(.NQ(NQ)) u_cause (
    .q_full (q_full),
    .q_cap  (q_cap),
    .q_bw   (q_bw),
    .q_ok   (q_ok),
    .q_rej  (q_rej)
  );

  modn_steer_search #(.NQ(NQ)) u_search (
    .ok        (q_ok),
    .start     (ptr),
    .loose_en  (loose_en),
    .hit       (hit),
    .idx       (pick),
    .via_loose (via_loose)
  );

  assign prim_free = q_free[int'(ptr) * FW +: FW];
  assign stall_evt = req && !q_ok[ptr] && (prim_free != '0);
  assign adv       = req && disp_ok && hit && !via_loose;

  modn_steer_ptr #(.NQ(NQ), .GROUP(GROUP)) u_ptr (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .ptr (ptr)
  );

  modn_steer_stats #(.FW(FW), .CW(CW), .AW(AW)) u_stats (
    .clk       (clk),
    .rst       (rst),
    .evt       (stall_evt),
    .free      (prim_free),
    .stall_cnt (stall_cnt),
    .free_acc  (free_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_found <= 1'b0;
      res_q     <= '0;
      res_loose <= 1'b0;
      res_cause <= RJ_NONE;
    end else begin
      res_valid <= req;
      if (req) begin
        res_found <= hit;
        res_q     <= pick;
        res_loose <= via_loose;
        res_cause <= hit ? RJ_NONE : q_rej[ptr];
      end
    end
  end

  // R3: a selected queue accepted in the request cycle
  p_found_ok_r3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_found) |-> ((($past(q_ok) >> res_q) & NQ'(1)) != '0));

  // R6: no relaxed placement unless the mode was on
  p_strict_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_loose) |-> $past(loose_en));

  // R5: a miss always carries a reject code
  p_miss_cause_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_found) |-> res_cause != RJ_NONE);

  // R7: a hit carries no reject code
  p_hit_clean_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_found) |-> res_cause == RJ_NONE);
endmodule

// File: tb/modn_steer_bench.sv
module modn_steer_bench;
  localparam int NQ = 4, FW = 4, GROUP = 2, CW = 8, AW = 10;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0, loose_en = 1'b0, disp_ok = 1'b0;
  logic [NQ-1:0] q_full = '0, q_cap = '0, q_bw = '0;
  logic [NQ*FW-1:0] q_free = '0;
  logic res_valid, res_found, res_loose;
  logic [IW-1:0] res_q;
  logic [1:0] res_cause;
  logic [CW-1:0] stall_cnt;
  logic [AW-1:0] free_acc;

  int checks = 0, fails = 0;
  string ph = "R1";

  // reference model state
  int m_ptr = 0, m_grp = 0, m_stall = 0, m_acc = 0;
  int e_valid = 0, e_found = 0, e_q = 0, e_loose = 0, e_cause = 0;

  always #2.5 clk = ~clk;

  modn_steer #(.NQ(NQ), .FW(FW), .GROUP(GROUP), .CW(CW), .AW(AW)) u_modn_steer (
    .clk(clk), .rst(rst), .req(req), .loose_en(loose_en), .disp_ok(disp_ok),
    .q_full(q_full), .q_cap(q_cap), .q_bw(q_bw), .q_free(q_free),
    .res_valid(res_valid), .res_found(res_found), .res_q(res_q),
    .res_loose(res_loose), .res_cause(res_cause),
    .stall_cnt(stall_cnt), .free_acc(free_acc)
  );

  function automatic int qcause(input int i);
    if (q_full[i]) return 1;
    if (q_cap[i])  return 2;
    if (q_bw[i])   return 3;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_grp = 0; m_stall = 0; m_acc = 0;
      e_valid = 0; e_found = 0; e_q = 0; e_loose = 0; e_cause = 0;
    end else begin
      e_valid = req;
      if (req) begin
        int pc, fr, hit, sel, lz;
        pc = qcause(m_ptr);
        fr = int'(q_free[m_ptr*FW +: FW]);
        hit = 0; sel = m_ptr; lz = 0;
        if (pc == 0) hit = 1;
        else if (loose_en) begin
          for (int k = 1; k < NQ; k++) begin
            if (!hit && qcause((m_ptr + k) % NQ) == 0) begin
              hit = 1; sel = (m_ptr + k) % NQ; lz = 1;
            end
          end
        end
        e_found = hit; e_q = sel; e_loose = lz;
        e_cause = hit ? 0 : pc;
        if (pc != 0 && fr != 0) begin
          m_stall = (m_stall + 1) % (1 << CW);
          m_acc = (m_acc + fr) % (1 << AW);
        end
        if (disp_ok && hit && !lz) begin
          m_grp = m_grp + 1;
          if (m_grp == GROUP) begin
            m_grp = 0;
            m_ptr = (m_ptr + 1) % NQ;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rt, input string fld, input int a, input int e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [phase %s] %s act=%0d exp=%0d", rt, ph, fld, a, e);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      string rt;
      if (e_loose != 0)                 rt = "R7";
      else if (e_found != 0)            rt = "R3";
      else if (e_cause != 0 && e_valid != 0) rt = "R5";
      else                              rt = "R6";
      chk(int'(res_valid) == e_valid, "R2", "res_valid", int'(res_valid), e_valid);
      chk(int'(res_found) == e_found, rt, "res_found", int'(res_found), e_found);
      chk(int'(res_q) == e_q, rt, "res_q", int'(res_q), e_q);
      chk(int'(res_loose) == e_loose, rt, "res_loose", int'(res_loose), e_loose);
      chk(int'(res_cause) == e_cause, rt, "res_cause", int'(res_cause), e_cause);
      chk(int'(stall_cnt) == m_stall, "R10", "stall_cnt", int'(stall_cnt), m_stall);
      chk(int'(free_acc) == m_acc, "R10", "free_acc", int'(free_acc), m_acc);
    end
  end

  task automatic drive(input bit r, input bit lz, input bit ok,
                       input logic [NQ-1:0] f, input logic [NQ-1:0] c,
                       input logic [NQ-1:0] b, input logic [NQ*FW-1:0] fr);
    @(negedge clk);
    req = r; loose_en = lz; disp_ok = ok;
    q_full = f; q_cap = c; q_bw = b; q_free = fr;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen at the ports
    @(negedge clk);
    chk(res_valid == 1'b0, "R1", "res_valid", int'(res_valid), 0);
    chk(stall_cnt == '0, "R1", "stall_cnt", int'(stall_cnt), 0);
    chk(free_acc == '0, "R1", "free_acc", int'(free_acc), 0);

    // R3 and R4: all queues accept, groups of GROUP per queue
    ph = "R4";
    for (int i = 0; i < 10; i++) drive(1, 0, 1, '0, '0, '0, '1);
    // R4: disp_ok low holds the pointer
    for (int i = 0; i < 4; i++) drive(1, 0, 0, '0, '0, '0, '1);
    drive(0, 0, 0, '0, '0, '0, '0);
    drive(0, 0, 0, '0, '0, '0, '0);

    // R5 and R6: strict mode, every primary reject code
    ph = "R5";
    drive(1, 0, 1, 4'b1111, 4'b1111, 4'b1111, {NQ{4'd3}});
    drive(1, 0, 1, 4'b0000, 4'b1111, 4'b1111, {NQ{4'd5}});
    drive(1, 0, 1, 4'b0000, 4'b0000, 4'b1111, {NQ{4'd7}});
    ph = "R6";
    drive(1, 0, 1, 4'b0000, 4'b0000, 4'b1111, {NQ{4'd0}});
    drive(1, 0, 1, 4'b1110, 4'b0000, 4'b0000, {NQ{4'd2}});

    // R7: relaxed search finds a later queue
    ph = "R7";
    drive(1, 1, 0, 4'b0111, 4'b0000, 4'b0000, {NQ{4'd1}});
    drive(1, 1, 0, 4'b0000, 4'b1011, 4'b0000, {NQ{4'd0}});
    // R8: every queue rejects, primary cause reported
    ph = "R8";
    drive(1, 1, 1, 4'b0000, 4'b1111, 4'b0000, {NQ{4'd4}});
    drive(1, 1, 1, 4'b1000, 4'b0000, 4'b0111, {NQ{4'd0}});

    // R9 and R11: relaxed placements with disp_ok, stall counted
    ph = "R11";
    for (int i = 0; i < 5; i++) drive(1, 1, 1, 4'b1111 ^ (4'b1 << ((i + 1) % NQ)), '0, '0, {NQ{4'd6}});
    ph = "R9";
    for (int i = 0; i < 3; i++) drive(1, 1, 1, '0, '0, '0, '1);

    // R10: mixed random traffic, includes counter wrap
    ph = "R10";
    for (int i = 0; i < 600; i++)
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 2) != 0,
            NQ'($urandom) & NQ'($urandom), NQ'($urandom) & NQ'($urandom),
            NQ'($urandom) & NQ'($urandom), (NQ*FW)'($urandom));
    drive(0, 0, 0, '0, '0, '0, '0);
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule